// File: doc/BRIEF.md
# Receive frame check status generator

This block sits behind a segmented receive datapath and issues per-beat status for frames as they end. Each beat carries several segments. Each segment has an enable, a start flag, an end flag, an error flag and an empty-byte count, plus the frame check word taken from the frame and the word that an upstream CRC engine computed for it. The CRC engine itself lies outside this block.

When a frame ends, the block compares the two check words. A match is good. A received word that equals the bitwise complement of the computed word is a deliberately stomped frame. Any other mismatch is a bad frame. The block also keeps a running byte count across segments and beats. Once a frame grows past a programmable limit, it raises a truncation pulse and drops the rest of that frame. The empty-byte field goes out registered, with its low bits cleared whenever the segment carries an error.

All outputs are registered and appear one clock after the beat that caused them.

Top module: `rx_fcs_status`

## Requirements
- R1: A frame that ends with its received check word equal to the computed word adds to neither the bad count nor the stomped count.
- R2: A frame that ends with its received check word equal to the bitwise inverse of the computed word adds one to `stomp_cnt_o` and nothing to `bad_cnt_o`.
- R3: A frame that ends with any other mismatching check word adds one to `bad_cnt_o`.
- R4: `bad_cnt_o` and `stomp_cnt_o` count the frames of each class that ended in one beat, so several can be reported in the same cycle. Each is valid for exactly one clock, one cycle after that beat, and they may be nonzero on consecutive cycles.
- R5: Each enabled segment adds SEG_BYTES bytes to the frame length. An enabled end segment instead adds SEG_BYTES minus its empty-byte count. A segment with its start flag set begins the count from zero and also cancels any drop state left by an earlier frame.
- R6: When the frame length first exceeds `max_len_i`, `trunc_o` pulses high for one cycle. A frame of exactly `max_len_i` bytes is not truncated.
- R7: After truncation, the remaining segments of that frame up to its end are discarded. No bad or stomped result is reported for that frame, including when the truncation happens in its end segment.
- R8: `mty_o` is the per-segment empty-byte field (segment s at bits [4s+3:4s] by default), registered. When a segment's enable and error are both high, its low MTY_W-1 bits are forced to zero and its top bit passes through unchanged.
- R9: While reset is held and after its release with no enabled segments, every output is zero.
- R10: A beat with no enabled segment produces no bad, stomped or truncation event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| max_len_i | input | MAXW (15) | Largest frame length in bytes that is not truncated |
| seg_ena_i | input | NSEG (4) | Segment enable, bit s for segment s |
| seg_sop_i | input | NSEG | Segment starts a frame |
| seg_eop_i | input | NSEG | Segment ends a frame |
| seg_err_i | input | NSEG | Segment carries an error |
| seg_mty_i | input | NSEG*MTY_W (16) | Empty bytes in an end segment, 4 bits per segment |
| rx_fcs_i | input | NSEG*FCS_W (128) | Check word taken from the frame, per segment |
| calc_fcs_i | input | NSEG*FCS_W | Check word computed upstream, per segment |
| bad_cnt_o | output | CNT_W (4) | Number of bad-check frames that ended in the previous beat |
| stomp_cnt_o | output | CNT_W | Number of stomped frames that ended in the previous beat |
| trunc_o | output | 1 | One-cycle truncation pulse |
| mty_o | output | NSEG*MTY_W | Registered empty-byte field with error forcing |

## Verification
The bench builds the block with its defaults: four segments of sixteen bytes and 32-bit check words. It drives `max_len_i` at 100 for the vector table and at 20 for the directed part. Four segments let one beat close up to four frames, so mixed good, bad and stomped counts in a single cycle can be checked. A limit of 100 lets a frame land exactly on the limit or one byte over it within two beats, including truncation in the end segment itself. The limit of 20 trips truncation in the second segment of a beat, and the directed tests also check that a new start segment clears the drop state.

// File: rtl/rfcs_pkg.sv
package rfcs_pkg;
  typedef enum logic [1:0] {
    FCS_NONE  = 2'd0,
    FCS_GOOD  = 2'd1,
    FCS_BAD   = 2'd2,
    FCS_STOMP = 2'd3
  } fcs_class_e;
endpackage

// File: rtl/rfcs_classify.sv
module rfcs_classify
  import rfcs_pkg::*;
#(
  parameter int FCS_W = 32
) (
  input  logic             vld_i,
  input  logic [FCS_W-1:0] rx_i,
  input  logic [FCS_W-1:0] calc_i,
  output fcs_class_e       cls_o
);
  logic match, inverse;
  assign match   = (rx_i == calc_i);
  assign inverse = (rx_i == ~calc_i);

  always_comb begin
    if (!vld_i)       cls_o = FCS_NONE;
    else if (match)   cls_o = FCS_GOOD;
    else if (inverse) cls_o = FCS_STOMP;
    else              cls_o = FCS_BAD;
  end
endmodule

// File: rtl/rfcs_len_stage.sv
module rfcs_len_stage #(
  parameter int SEG_BYTES = 16,
  parameter int MTY_W     = 4,
  parameter int MAXW      = 15,
  parameter int LEN_W     = 16
) (
  input  logic             ena_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [MTY_W-1:0] mty_i,
  input  logic [MAXW-1:0]  max_len_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             drop_i,
  output logic [LEN_W-1:0] len_o,
  output logic             drop_o,
  output logic             trunc_o,
  output logic             judge_o
);
  localparam int BYTE_W = $clog2(SEG_BYTES + 1);

  logic [BYTE_W-1:0] seg_bytes;
  logic [LEN_W-1:0]  base_len, new_len;
  logic [LEN_W:0]    sum;
  logic              base_drop, over;

  assign seg_bytes = eop_i ? (BYTE_W'(SEG_BYTES) - BYTE_W'(mty_i)) : BYTE_W'(SEG_BYTES);
  assign base_len  = sop_i ? '0 : len_i;
  assign base_drop = sop_i ? 1'b0 : drop_i;
  assign sum       = {1'b0, base_len} + (LEN_W+1)'(seg_bytes);
  // saturate so a runaway frame cannot wrap back under the limit
  assign new_len   = sum[LEN_W] ? '1 : sum[LEN_W-1:0];
  assign over      = ena_i && !base_drop && (new_len > LEN_W'(max_len_i));

  always_comb begin
    if (!ena_i) begin
      len_o   = len_i;
      drop_o  = drop_i;
      trunc_o = 1'b0;
      judge_o = 1'b0;
    end else begin
      len_o   = eop_i ? '0 : new_len;
      drop_o  = (base_drop || over) && !eop_i;
      trunc_o = over;
      judge_o = eop_i && !base_drop && !over;
    end
  end
endmodule

// File: rtl/rfcs_popcnt.sv
module rfcs_popcnt #(
  parameter int N     = 4,
  parameter int CNT_W = 4
) (
  input  logic [N-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/rx_fcs_status.sv
module rx_fcs_status
  import rfcs_pkg::*;
#(
  parameter int NSEG      = 4,
  parameter int SEG_BYTES = 16,
  parameter int FCS_W     = 32,
  parameter int MAXW      = 15,
  parameter int CNT_W     = 4,
  parameter int MTY_W     = $clog2(SEG_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [MAXW-1:0]         max_len_i,
  input  logic [NSEG-1:0]         seg_ena_i,
  input  logic [NSEG-1:0]         seg_sop_i,
  input  logic [NSEG-1:0]         seg_eop_i,
  input  logic [NSEG-1:0]         seg_err_i,
  input  logic [NSEG*MTY_W-1:0]   seg_mty_i,
  input  logic [NSEG*FCS_W-1:0]   rx_fcs_i,
  input  logic [NSEG*FCS_W-1:0]   calc_fcs_i,
  output logic [CNT_W-1:0]        bad_cnt_o,
  output logic [CNT_W-1:0]        stomp_cnt_o,
  output logic                    trunc_o,
  output logic [NSEG*MTY_W-1:0]   mty_o
);
  localparam int LEN_W = MAXW + 1;

  logic [LEN_W-1:0]       len_q;
  logic                   drop_q;
  logic [LEN_W-1:0]       len_c [NSEG+1];
  logic [NSEG:0]          drop_c;
  logic [NSEG-1:0]        trunc_v, judge_v, bad_v, stomp_v;
  logic [NSEG*MTY_W-1:0]  mty_fix;
  logic [CNT_W-1:0]       bad_n, stomp_n;

  assign len_c[0]  = len_q;
  assign drop_c[0] = drop_q;

  // segments are walked in order 0..NSEG-1 within a beat
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    fcs_class_e cls;

    rfcs_len_stage #(
      .SEG_BYTES(SEG_BYTES), .MTY_W(MTY_W), .MAXW(MAXW), .LEN_W(LEN_W)
    ) u_len (
      .ena_i    (seg_ena_i[s]),
      .sop_i    (seg_sop_i[s]),
      .eop_i    (seg_eop_i[s]),
      .mty_i    (seg_mty_i[s*MTY_W +: MTY_W]),
      .max_len_i(max_len_i),
      .len_i    (len_c[s]),
      .drop_i   (drop_c[s]),
      .len_o    (len_c[s+1]),
      .drop_o   (drop_c[s+1]),
      .trunc_o  (trunc_v[s]),
      .judge_o  (judge_v[s])
    );

    rfcs_classify #(.FCS_W(FCS_W)) u_cls (
      .vld_i (judge_v[s]),
      .rx_i  (rx_fcs_i[s*FCS_W +: FCS_W]),
      .calc_i(calc_fcs_i[s*FCS_W +: FCS_W]),
      .cls_o (cls)
    );

    assign bad_v[s]   = (cls == FCS_BAD);
    assign stomp_v[s] = (cls == FCS_STOMP);

    // error beats keep only the top bit of the empty count
    assign mty_fix[s*MTY_W +: MTY_W] = (seg_ena_i[s] && seg_err_i[s])
        ? {seg_mty_i[s*MTY_W + MTY_W-1], {(MTY_W-1){1'b0}}}
        : seg_mty_i[s*MTY_W +: MTY_W];
  end

  rfcs_popcnt #(.N(NSEG), .CNT_W(CNT_W)) u_bad_cnt (
    .vec_i(bad_v), .cnt_o(bad_n)
  );

  rfcs_popcnt #(.N(NSEG), .CNT_W(CNT_W)) u_stomp_cnt (
    .vec_i(stomp_v), .cnt_o(stomp_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q       <= '0;
      drop_q      <= 1'b0;
      bad_cnt_o   <= '0;
      stomp_cnt_o <= '0;
      trunc_o     <= 1'b0;
      mty_o       <= '0;
    end else begin
      len_q       <= len_c[NSEG];
      drop_q      <= drop_c[NSEG];
      bad_cnt_o   <= bad_n;
      stomp_cnt_o <= stomp_n;
      trunc_o     <= |trunc_v;
      mty_o       <= mty_fix;
    end
  end
endmodule

// File: rtl/rx_fcs_status_chk.sv
module rx_fcs_status_chk #(
  parameter int NSEG      = 4,
  parameter int SEG_BYTES = 16,
  parameter int FCS_W     = 32,
  parameter int MAXW      = 15,
  parameter int CNT_W     = 4,
  parameter int MTY_W     = $clog2(SEG_BYTES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NSEG-1:0]       seg_ena_i,
  input logic [NSEG-1:0]       seg_eop_i,
  input logic [NSEG-1:0]       seg_err_i,
  input logic [NSEG*MTY_W-1:0] seg_mty_i,
  input logic [NSEG*FCS_W-1:0] rx_fcs_i,
  input logic [NSEG*FCS_W-1:0] calc_fcs_i,
  input logic [CNT_W-1:0]      bad_cnt_o,
  input logic [CNT_W-1:0]      stomp_cnt_o,
  input logic                  trunc_o,
  input logic [NSEG*MTY_W-1:0] mty_o
);
  logic [NSEG-1:0] end_v, good_v;

  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    assign end_v[s]  = seg_ena_i[s] && seg_eop_i[s];
    assign good_v[s] = rx_fcs_i[s*FCS_W +: FCS_W] == calc_fcs_i[s*FCS_W +: FCS_W];

    // R8: error beat clears low empty bits
    a_r8_mty_err_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seg_ena_i[s] && seg_err_i[s]) |=> (mty_o[s*MTY_W +: MTY_W-1] == '0));

    // R8: top empty bit always follows the input
    a_r8_mty_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mty_o[s*MTY_W + MTY_W-1] == $past(seg_mty_i[s*MTY_W + MTY_W-1]));
  end

  // R1: all ending frames good -> no events
  a_r1_good_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((end_v & ~good_v) == '0) |=> (bad_cnt_o == '0 && stomp_cnt_o == '0));

  // R4: never more events than frames ending in the beat
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(bad_cnt_o) + 32'(stomp_cnt_o)) <= 32'($past($countones(end_v))));

  // R10: idle beat is quiet
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_ena_i == '0) |=> (!trunc_o && bad_cnt_o == '0 && stomp_cnt_o == '0));

  // R6: truncation only follows a beat with data
  a_r6_trunc_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trunc_o |-> $past(|seg_ena_i));
endmodule

bind rx_fcs_status rx_fcs_status_chk #(
  .NSEG(NSEG), .SEG_BYTES(SEG_BYTES), .FCS_W(FCS_W),
  .MAXW(MAXW), .CNT_W(CNT_W), .MTY_W(MTY_W)
) u_chk (.*);

// File: tb/rx_fcs_status_bench.sv
`timescale 1ns/1ps
module rx_fcs_status_bench;
  localparam int NSEG = 4;
  localparam int FCS_W = 32;
  localparam int MTY_W = 4;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [3:0]  ena;
    logic [3:0]  sop;
    logic [3:0]  eop;
    logic [3:0]  err;
    logic [7:0]  kind;   // 2 bits per segment: 0 good, 1 stomped, 2 bad
    logic [15:0] mty;
    logic [2:0]  ebad;
    logic [2:0]  estp;
    logic        etrunc;
  } vec_t;

  // max_len_i = 100 for all rows
  localparam vec_t VECS [14] = '{
    '{4'b0001, 4'b0001, 4'b0001, 4'b0000, 8'h00,       16'h0004, 3'd0, 3'd0, 1'b0}, // R1 good single
    '{4'b1111, 4'b1111, 4'b1111, 4'b0000, 8'b10100100, 16'h0000, 3'd2, 3'd1, 1'b0}, // R2 R3 R4 mixed
    '{4'b0011, 4'b0011, 4'b0011, 4'b0010, 8'b00000101, 16'h00F0, 3'd0, 3'd2, 1'b0}, // R4 back-to-back, R8
    '{4'b1111, 4'b0001, 4'b0000, 4'b0000, 8'h00,       16'h0000, 3'd0, 3'd0, 1'b0}, // R5 64 bytes
    '{4'b0111, 4'b0100, 4'b0110, 4'b0000, 8'b00001000, 16'h0700, 3'd1, 3'd0, 1'b0}, // R5 96 bytes bad
    '{4'b1111, 4'b0001, 4'b0000, 4'b0000, 8'h00,       16'h0000, 3'd0, 3'd0, 1'b0},
    '{4'b1111, 4'b0000, 4'b0000, 4'b0000, 8'h00,       16'h0000, 3'd0, 3'd0, 1'b1}, // R6 112 > 100
    '{4'b0011, 4'b0010, 4'b0011, 4'b0000, 8'b00000110, 16'h0000, 3'd0, 3'd1, 1'b0}, // R7 dropped bad end
    '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'b10101010, 16'h0000, 3'd0, 3'd0, 1'b0}, // R10 idle
    '{4'b1111, 4'b0001, 4'b0000, 4'b0000, 8'h00,       16'h0000, 3'd0, 3'd0, 1'b0},
    '{4'b0111, 4'b0000, 4'b0100, 4'b0000, 8'b00010000, 16'h0C00, 3'd0, 3'd1, 1'b0}, // R6 exactly 100
    '{4'b1111, 4'b0001, 4'b0000, 4'b0000, 8'h00,       16'h0000, 3'd0, 3'd0, 1'b0},
    '{4'b0111, 4'b0000, 4'b0100, 4'b0000, 8'b00010000, 16'h0B00, 3'd0, 3'd0, 1'b1}, // R7 101 trunc at end
    '{4'b0001, 4'b0001, 4'b0001, 4'b0001, 8'h00,       16'h000D, 3'd0, 3'd0, 1'b0}  // R8 D -> 8
  };

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [14:0]             max_len_i = 15'd100;
  logic [NSEG-1:0]         seg_ena_i = '0, seg_sop_i = '0, seg_eop_i = '0, seg_err_i = '0;
  logic [NSEG*MTY_W-1:0]   seg_mty_i = '0;
  logic [NSEG*FCS_W-1:0]   rx_fcs_i = '0, calc_fcs_i = '0;
  logic [CNT_W-1:0]        bad_cnt_o, stomp_cnt_o;
  logic                    trunc_o;
  logic [NSEG*MTY_W-1:0]   mty_o;
  logic [15:0]             exp_mty;
  int nchk = 0, nfail = 0;

  always #2 clk_i = ~clk_i;

  rx_fcs_status u_rx_fcs_status (.*);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    seg_ena_i = v.ena; seg_sop_i = v.sop; seg_eop_i = v.eop; seg_err_i = v.err;
    seg_mty_i = v.mty;
    exp_mty = v.mty;
    for (int s = 0; s < NSEG; s++) begin
      logic [31:0] c;
      c = 32'h1234_5670 + s * 32'h0101_0101;
      calc_fcs_i[s*FCS_W +: FCS_W] = c;
      case (v.kind[2*s +: 2])
        2'd0:    rx_fcs_i[s*FCS_W +: FCS_W] = c;
        2'd1:    rx_fcs_i[s*FCS_W +: FCS_W] = ~c;
        default: rx_fcs_i[s*FCS_W +: FCS_W] = c ^ 32'h0000_0010;
      endcase
      if (v.ena[s] && v.err[s]) exp_mty[4*s +: 3] = 3'b000;
    end
  endtask

  task automatic check_out(input vec_t v);
    chk("R3 bad count", int'(bad_cnt_o), int'(v.ebad));
    chk("R2 stomp count", int'(stomp_cnt_o), int'(v.estp));
    chk("R6 trunc", int'(trunc_o), int'(v.etrunc));
    chk("R8 mty", int'(mty_o), int'(exp_mty));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 outputs zero in reset
    chk("R9 bad in reset", int'(bad_cnt_o), 0);
    chk("R9 trunc in reset", int'(trunc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 stomp after reset", int'(stomp_cnt_o), 0);
    chk("R9 mty after reset", int'(mty_o), 0);

    foreach (VECS[i]) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check_out(VECS[i]);
    end

    // directed, limit 20
    max_len_i = 15'd20;
    drive('{4'b0001, 4'b0001, 4'b0001, 4'b0000, 8'h00, 16'h0000, 3'd0, 3'd0, 1'b0});
    @(negedge clk_i);
    chk("R6 16 within 20", int'(trunc_o), 0);
    chk("R1 good", int'(bad_cnt_o) + int'(stomp_cnt_o), 0);
    drive('{4'b1111, 4'b0001, 4'b0000, 4'b0000, 8'h00, 16'h0000, 3'd0, 3'd0, 1'b0});
    @(negedge clk_i);
    chk("R6 trunc in second segment", int'(trunc_o), 1);
    // R5 R7: new start clears length and drop
    drive('{4'b0001, 4'b0001, 4'b0001, 4'b0000, 8'b00000010, 16'h0000, 3'd0, 3'd0, 1'b0});
    @(negedge clk_i);
    chk("R5 restart no trunc", int'(trunc_o), 0);
    chk("R7 restart judged bad", int'(bad_cnt_o), 1);
    drive('{4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'h00, 16'h0000, 3'd0, 3'd0, 1'b0});
    @(negedge clk_i);
    chk("R4 one-cycle bad pulse", int'(bad_cnt_o), 0);
    chk("R10 idle trunc", int'(trunc_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule